// File: doc/BRIEF.md
# System Reset Cause and Trigger Register

This block holds one 32-bit word that records why the system last came out of reset, and it lets software start a new system reset. Five cause flags sit in the top bits of the word. The first system reset after power-up marks the power-on flag. Two button event inputs mark the button flags. Software clears the flags it has handled and sets the two software-reset flags. A write that sets either software-reset flag also produces a single-cycle reset request at the output.

The block has two resets. `pwr_on_n` is the power-up reset. It is asynchronous, clears all state, and is meant to be asserted only when power is applied. `sys_rst_n` is the ordinary system reset. The block counts each time it is entered. Only the first entry after power-up loads the word. Every later entry leaves the word alone, so software can still read the cause after the reset it requested. The count stops at its maximum and never wraps, so it cannot reload the word by mistake.

Top module: `rst_cause_reg`

## Requirements
- R1: While `pwr_on_n` is low and after it is released, the word reads 0x00000000 and `sys_rst_req` is low.
- R2: The first clock on which `sys_rst_n` is low after power-up loads the word with exactly 0x80000000 (bit 31 only), unless a button event arrives on that same clock.
- R3: Every later entry into system reset leaves the word unchanged, even after more than 2^CNT_W entries. The entry count saturates and does not wrap.
- R4: A read at any address from BASE_ADDR to BASE_ADDR+7 (address bits above bit 2 equal to BASE_ADDR's) returns the full word. Any other address returns zero.
- R5: Bits 31, 28 and 27 are write-one-to-clear. Writing a 1 clears the bit and writing a 0 leaves it unchanged.
- R6: Bits 30 and 29 take the written value directly.
- R7: Bits 26:0 always read zero, and writes to them have no effect.
- R8: A write in the window with bit 30 or bit 29 set makes `sys_rst_req` high for exactly the one cycle after that write's clock edge. Any other write does not raise it.
- R9: A pulse on `btn_por_evt` sets bit 28 and a pulse on `btn_xir_evt` sets bit 27. A set wins over a clear written on the same clock.
- R10: Writes outside the window, and writes made while `sys_rst_n` is low, change nothing and raise no request.
- R11: `sys_rst_req` is never high on the cycle after a clock with `sys_rst_n` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_on_n | input | 1 | Power-up reset, asynchronous, active low; clears everything |
| sys_rst_n | input | 1 | System reset, sampled on the clock, active low; counted |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte address for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| btn_por_evt | input | 1 | Button power-on event pulse |
| btn_xir_evt | input | 1 | Button external-reset event pulse |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The counter and the previous-reset flag cannot be seen directly. A fault in either shows up only as a wrong word after some later reset. For example, a counter that wraps or misses entries either reloads 0x80000000 on a later reset, or fails to load it on the first. So the bench runs more than 2^CNT_W resets and reads the word after them. A wrong flag bit shows at the port on the first read after the clock that caused it. A wrong request decode shows on `sys_rst_req` one cycle after the write.

// File: rtl/rst_cause_reg.sv
module rst_cause_reg #(
  parameter int              ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hF020,
  parameter int              CNT_W     = 4
) (
  input  logic              clk,
  input  logic              pwr_on_n,
  input  logic              sys_rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              btn_por_evt,
  input  logic              btn_xir_evt,
  output logic              sys_rst_req
);

  localparam int         WIN_LSB = 3;
  localparam int         FLAGS   = 5;
  localparam int         LOW_W   = 32 - FLAGS;
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  // flag index: 4=bit31 3=bit30 2=bit29 1=bit28 0=bit27
  localparam logic [FLAGS-1:0] CLR_MASK = 5'b10011;
  localparam logic [FLAGS-1:0] RW_MASK  = 5'b01100;
  localparam logic [FLAGS-1:0] POR_VAL  = 5'b10000;

  logic [FLAGS-1:0] flag_q;
  logic [CNT_W-1:0] entry_cnt_q;
  logic             rst_prev_q;

  wire hit       = bus_addr[ADDR_W-1:WIN_LSB] == BASE_ADDR[ADDR_W-1:WIN_LSB];
  wire wr_ok     = bus_wr & hit & sys_rst_n;
  wire rst_entry = ~sys_rst_n & rst_prev_q;
  wire first_rst = rst_entry & (entry_cnt_q == '0);

  wire [FLAGS-1:0] wd      = bus_wdata[31:LOW_W];
  wire [FLAGS-1:0] wr_val  = (flag_q & ~(wd & CLR_MASK) & ~RW_MASK) | (wd & RW_MASK);
  wire [FLAGS-1:0] btn_set = {3'b000, btn_por_evt, btn_xir_evt};
  wire [FLAGS-1:0] flag_d  = (first_rst ? POR_VAL : wr_ok ? wr_val : flag_q) | btn_set;

  assign bus_rdata = hit ? {flag_q, {LOW_W{1'b0}}} : 32'h0;

  always_ff @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      flag_q      <= '0;
      entry_cnt_q <= '0;
      rst_prev_q  <= 1'b1;
      sys_rst_req <= 1'b0;
    end else begin
      flag_q      <= flag_d;
      rst_prev_q  <= sys_rst_n;
      sys_rst_req <= wr_ok & (wd[3] | wd[2]);
      if (rst_entry && entry_cnt_q != CNT_MAX)
        entry_cnt_q <= entry_cnt_q + 1'b1;
    end
  end

  assert_req_cause_R8: assert property (@(posedge clk) disable iff (!pwr_on_n)
    sys_rst_req |-> $past(bus_wr && hit && sys_rst_n && (bus_wdata[30] || bus_wdata[29])));

  assert_no_req_after_rst_R11: assert property (@(posedge clk) disable iff (!pwr_on_n)
    !sys_rst_n |=> !sys_rst_req);

  assert_btn_set_R9: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (btn_por_evt && btn_xir_evt) |=> (flag_q[1:0] == 2'b11));

  assert_first_load_R2: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (first_rst && !btn_por_evt && !btn_xir_evt) |=> (flag_q == POR_VAL));

  assert_hold_in_rst_R3: assert property (@(posedge clk) disable iff (!pwr_on_n)
    (!sys_rst_n && !rst_prev_q && !btn_por_evt && !btn_xir_evt) |=> $stable(flag_q));

endmodule

// File: tb/rst_cause_reg_tb.sv
module rst_cause_reg_tb;
  localparam int ADDR_W = 16;
  localparam logic [ADDR_W-1:0] BASE = 16'hF020;
  localparam int CNT_W = 4;

  logic clk = 1'b0;
  logic pwr_on_n = 1'b0, sys_rst_n = 1'b1, bus_wr = 1'b0;
  logic [ADDR_W-1:0] bus_addr = BASE;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic btn_por_evt = 1'b0, btn_xir_evt = 1'b0, sys_rst_req;

  rst_cause_reg #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .pwr_on_n(pwr_on_n), .sys_rst_n(sys_rst_n), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .btn_por_evt(btn_por_evt), .btn_xir_evt(btn_xir_evt), .sys_rst_req(sys_rst_req));

  always #4 clk = ~clk;

  int compared = 0, mismatched = 0, cyc = 0;
  string phase = "R1";
  bit done = 0;

  // reference model
  logic [31:0] m_word;
  int m_resets;
  bit m_in_rst, m_req;

  function automatic bit in_win(logic [ADDR_W-1:0] a);
    return (a >= BASE) && (a <= BASE + 7);
  endfunction

  always @(posedge clk or negedge pwr_on_n) begin
    if (!pwr_on_n) begin
      m_word = 0; m_resets = 0; m_in_rst = 0; m_req = 0;
    end else begin
      bit wok;
      bit entering;
      wok = bus_wr && in_win(bus_addr) && sys_rst_n;
      m_req = wok && (bus_wdata[30] || bus_wdata[29]);
      entering = !sys_rst_n && !m_in_rst;
      if (entering && m_resets == 0) m_word = 32'h8000_0000;
      else if (wok) begin
        m_word = m_word & ~(bus_wdata & 32'h9800_0000);
        m_word = (m_word & ~32'h6000_0000) | (bus_wdata & 32'h6000_0000);
      end
      if (entering && m_resets < (1 << CNT_W) - 1) m_resets++;
      if (btn_por_evt) m_word[28] = 1'b1;
      if (btn_xir_evt) m_word[27] = 1'b1;
      m_in_rst = !sys_rst_n;
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    exp_rd = in_win(bus_addr) ? m_word : 32'h0;
    compared++;
    if (bus_rdata !== exp_rd) begin
      mismatched++;
      $display("FAIL %s: bus_rdata actual %h expected %h (addr %h)", phase, bus_rdata, exp_rd, bus_addr);
    end
    compared++;
    if (sys_rst_req !== m_req) begin
      mismatched++;
      $display("FAIL %s: sys_rst_req actual %b expected %b", phase, sys_rst_req, m_req);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000 && !done) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic tick(int n = 1);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic idle(int n = 1);
    bus_wr = 0; bus_addr = BASE; btn_por_evt = 0; btn_xir_evt = 0;
    tick(n);
  endtask

  task automatic wr(logic [ADDR_W-1:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    tick();
    bus_wr = 0; bus_addr = BASE;
  endtask

  task automatic sysrst(int n);
    sys_rst_n = 0; tick(n); sys_rst_n = 1; tick();
  endtask

  initial begin
    phase = "R1"; tick(3); pwr_on_n = 1; idle(3);
    phase = "R2"; sysrst(3); idle(2);
    phase = "R4";
    foreach (bus_addr[i]) ; // no-op
    bus_addr = BASE + 4; tick(); bus_addr = BASE + 7; tick();
    bus_addr = BASE + 8; tick(); bus_addr = BASE - 1; tick();
    bus_addr = 16'h0000; tick(); idle();
    phase = "R6"; wr(BASE + 4, 32'h6000_0000); idle(2);
    wr(BASE, 32'h2000_0000); idle(); wr(BASE, 32'h0000_0000); idle(2);
    phase = "R5";
    btn_por_evt = 1; btn_xir_evt = 1; tick(); idle();
    wr(BASE, 32'h0800_0000); idle();
    wr(BASE, 32'h0000_0000); idle();
    wr(BASE, 32'h9000_0000); idle(2);
    phase = "R7"; wr(BASE, 32'h07FF_FFFF); idle(2);
    phase = "R9";
    btn_xir_evt = 1; wr(BASE, 32'h0800_0000); idle();
    btn_por_evt = 1; btn_xir_evt = 1; wr(BASE, 32'h1800_0000); idle(2);
    phase = "R10";
    wr(BASE + 8, 32'hFFFF_FFFF); wr(BASE - 8, 32'h6000_0000); idle();
    sys_rst_n = 0; wr(BASE, 32'hFFFF_FFFF); tick(); sys_rst_n = 1; idle(2);
    phase = "R11";
    sys_rst_n = 0; wr(BASE, 32'h4000_0000); sys_rst_n = 1; idle(2);
    phase = "R8";
    wr(BASE, 32'h4000_0000); wr(BASE + 2, 32'h2000_0000); wr(BASE, 32'h0000_0000);
    wr(BASE, 32'h9800_0000); idle(3);
    phase = "R3";
    wr(BASE, 32'h4000_0000); btn_por_evt = 1; tick(); idle();
    for (int k = 0; k < 20; k++) begin
      sysrst(2);
      idle();
    end
    btn_xir_evt = 1; sys_rst_n = 0; tick(); sys_rst_n = 1; idle(2);
    phase = "R1"; pwr_on_n = 0; tick(2); pwr_on_n = 1; idle(2);
    phase = "R2"; btn_xir_evt = 1; sys_rst_n = 0; tick(); btn_xir_evt = 0; tick(); sys_rst_n = 1; idle(3);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule